// File: doc/BRIEF.md
# Command Latency Scheduler for a DDR3-Style Memory Controller

This unit sits in the controller side of a DDR3-style memory interface. It watches the command stream and decides which commands may issue on the current cycle. For each accepted READ it raises a read-capture window, and for each accepted WRITE a write-drive window. The window starts a programmable number of cycles after the command and lasts as long as the burst: a full eight-beat burst or a chopped four-beat burst. The start of every window is the sum of an additive latency and a CAS latency. Reads use the read CAS latency and writes use the separate write CAS latency.

The unit also keeps a shadow of the latency-bearing mode register. That register holds the additive latency, read CAS latency, write CAS latency, an auto self-refresh flag, a self-refresh temperature flag and a two-bit write-termination code. A mode register write is accepted only while every bank is closed and no data window is pending or active. After it is accepted, two separate waits are enforced: one before the next mode register write, and a longer one before any other command.

Per-bank tracking makes sure that a READ or WRITE goes only to an open bank, and only after the row-to-column delay has passed since that bank's ACTIVATE.

Top module: `ddr_lat_sched`

## Requirements
- R1: After reset, `rd_capture` and `wr_drive` are low, all banks are closed, and the shadow settings are AL=0, CL=5, CWL=5, with the self-refresh flags and the termination code at 0.
- R2: Commands are coded on `cmd_op` as 0 NOP, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE and 5 mode register write. Codes 6 and 7 are always refused. A command takes effect in the cycle where both `cmd_valid` and `cmd_ready` are high.
- R3: For a READ presented in cycle c, `rd_capture` first goes high in cycle c+AL+CL. For AL=5 and CL=6 this is cycle c+11.
- R4: For a WRITE presented in cycle c, `wr_drive` first goes high in cycle c+AL+CWL, using the write CAS latency and not the read CAS latency.
- R5: Each window lasts 4 cycles when `cmd_bc4`=0 and 2 cycles when `cmd_bc4`=1. Two commands whose windows do not overlap each produce their own window, with the window signal low between them.
- R6: A READ or WRITE is refused unless its bank is open and at least TRCD cycles (default 3) have passed since that bank's ACTIVATE. An ACTIVATE to an open bank is refused. A PRECHARGE closes its bank.
- R7: A mode register write is refused while any bank is open or while any read or write window is pending or active. It becomes acceptable in the first cycle after the last window cycle.
- R8: `mr_wdata` carries AL in [3:0], CL in [7:4], CWL in [11:8], auto self-refresh in [12], self-refresh temperature in [13] and the termination code in [15:14]. The `cfg_*` outputs show the new values from the cycle after acceptance.
- R9: After a mode register write is accepted in cycle m, another mode register write is refused before cycle m+TMRD (default 4). Every other non-NOP command is refused before cycle m+TMOD (default 12).
- R10: Reset restores the default settings of R1 and closes all banks. Settings persist until the next mode register write or reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | Command code (R2) |
| cmd_bank | input | BANK_W (3) | Target bank |
| cmd_bc4 | input | 1 | Chopped four-beat burst when high |
| mr_wdata | input | 3*LAT_W+4 (16) | Mode register write payload (R8) |
| cmd_ready | output | 1 | The presented command may issue this cycle |
| rd_capture | output | 1 | Read data capture window |
| wr_drive | output | 1 | Write data drive window |
| cfg_al | output | LAT_W (4) | Additive latency in use |
| cfg_cl | output | LAT_W (4) | Read CAS latency in use |
| cfg_cwl | output | LAT_W (4) | Write CAS latency in use |
| cfg_asr | output | 1 | Auto self-refresh flag |
| cfg_srt | output | 1 | Self-refresh temperature flag |
| cfg_rtt_wr | output | 2 | Write-termination code |

## Verification
Four properties are checked on every cycle:
- a mode register write is only ever accepted with all banks closed and no burst window outstanding;
- the spacing since the last mode register write meets TMRD for another mode register write and TMOD for any other command;
- reads and writes only reach open banks;
- the shadow settings never change except right after an accepted mode register write.

The exact first and last cycle of each window needs the directed scenarios. So do the burst lengths, the separation of back-to-back windows, the refused-then-accepted boundaries for TRCD, TMRD and TMOD, and the field layout of the mode register payload. The bench observes all of these at the ports.

// File: rtl/lat_pkg.sv
package lat_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4,
    OP_MRS = 3'd5
  } op_e;

  localparam int FULL_BEATS = 4;  // clocks of an eight-beat burst
  localparam int CHOP_BEATS = 2;  // clocks of a chopped burst
endpackage

// File: rtl/lat_bank_track.sv
module lat_bank_track #(
  parameter int BANK_W = 3,
  parameter int TRCD   = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  act_fire,
  input  logic                  pre_fire,
  input  logic [BANK_W-1:0]     bank,
  output logic [(2**BANK_W)-1:0] open_o,
  output logic [(2**BANK_W)-1:0] rcd_ok_o
);
  localparam int NB    = 2**BANK_W;
  localparam int CNT_W = $clog2(TRCD + 1);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic             open_q;
    logic [CNT_W-1:0] rcd_cnt;

    always_ff @(posedge clk) begin
      if (rst) begin
        open_q  <= 1'b0;
        rcd_cnt <= '0;
      end else if (act_fire && (bank == BANK_W'(b))) begin
        open_q  <= 1'b1;
        rcd_cnt <= CNT_W'(TRCD - 1);
      end else begin
        if (pre_fire && (bank == BANK_W'(b)))
          open_q <= 1'b0;
        if (rcd_cnt != '0)
          rcd_cnt <= rcd_cnt - 1'b1;
      end
    end

    assign open_o[b]   = open_q;
    assign rcd_ok_o[b] = (rcd_cnt == '0);
  end
endmodule

// File: rtl/lat_mr_gate.sv
module lat_mr_gate #(
  parameter int LAT_W   = 4,
  parameter int TMRD    = 4,
  parameter int TMOD    = 12,
  parameter int CL_RST  = 5,
  parameter int CWL_RST = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mrs_fire,
  input  logic [3*LAT_W+3:0]   wdata,
  output logic                 mrd_ok,
  output logic                 mod_ok,
  output logic [LAT_W-1:0]     al,
  output logic [LAT_W-1:0]     cl,
  output logic [LAT_W-1:0]     cwl,
  output logic                 asr,
  output logic                 srt,
  output logic [1:0]           rtt
);
  localparam int MRD_W = $clog2(TMRD + 1);
  localparam int MOD_W = $clog2(TMOD + 1);
  localparam int F_CL  = LAT_W;
  localparam int F_CWL = 2 * LAT_W;
  localparam int F_FLG = 3 * LAT_W;

  logic [MRD_W-1:0] mrd_cnt;
  logic [MOD_W-1:0] mod_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      mrd_cnt <= '0;
      mod_cnt <= '0;
    end else if (mrs_fire) begin
      mrd_cnt <= MRD_W'(TMRD - 1);
      mod_cnt <= MOD_W'(TMOD - 1);
    end else begin
      if (mrd_cnt != '0) mrd_cnt <= mrd_cnt - 1'b1;
      if (mod_cnt != '0) mod_cnt <= mod_cnt - 1'b1;
    end
  end

  // Shadow copy; loaded only with all banks closed and no bursts outstanding,
  // so no in-flight command can observe the change.
  always_ff @(posedge clk) begin
    if (rst) begin
      al  <= '0;
      cl  <= LAT_W'(CL_RST);
      cwl <= LAT_W'(CWL_RST);
      asr <= 1'b0;
      srt <= 1'b0;
      rtt <= 2'b00;
    end else if (mrs_fire) begin
      al  <= wdata[LAT_W-1:0];
      cl  <= wdata[F_CL +: LAT_W];
      cwl <= wdata[F_CWL +: LAT_W];
      asr <= wdata[F_FLG];
      srt <= wdata[F_FLG+1];
      rtt <= wdata[F_FLG+2 +: 2];
    end
  end

  assign mrd_ok = (mrd_cnt == '0);
  assign mod_ok = (mod_cnt == '0);
endmodule

// File: rtl/lat_win_pipe.sv
module lat_win_pipe
  import lat_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int SH_W  = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fire,
  input  logic [SH_W-1:0] start_sh,
  input  logic            chop,
  output logic            win_o,
  output logic            busy_o
);
  logic [DEPTH-1:0] sched;
  logic [DEPTH-1:0] mask;
  int               len;

  // Bit k of sched reaches the output register k+1 cycles later.
  always_comb begin
    len = chop ? CHOP_BEATS : FULL_BEATS;
    for (int j = 0; j < DEPTH; j++)
      mask[j] = fire && (j >= int'(start_sh)) && (j < int'(start_sh) + len);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sched <= '0;
      win_o <= 1'b0;
    end else begin
      sched <= (sched >> 1) | mask;
      win_o <= sched[0];
    end
  end

  assign busy_o = (|sched) | win_o;
endmodule

// File: rtl/ddr_lat_sched.sv
module ddr_lat_sched
  import lat_pkg::*;
#(
  parameter int BANK_W  = 3,
  parameter int LAT_W   = 4,
  parameter int TRCD    = 3,
  parameter int TMRD    = 4,
  parameter int TMOD    = 12,
  parameter int CL_RST  = 5,
  parameter int CWL_RST = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_op,
  input  logic [BANK_W-1:0]    cmd_bank,
  input  logic                 cmd_bc4,
  input  logic [3*LAT_W+3:0]   mr_wdata,
  output logic                 cmd_ready,
  output logic                 rd_capture,
  output logic                 wr_drive,
  output logic [LAT_W-1:0]     cfg_al,
  output logic [LAT_W-1:0]     cfg_cl,
  output logic [LAT_W-1:0]     cfg_cwl,
  output logic                 cfg_asr,
  output logic                 cfg_srt,
  output logic [1:0]           cfg_rtt_wr
);
  localparam int NB    = 2**BANK_W;
  localparam int LMAX  = 2**LAT_W - 1;
  localparam int SH_W  = LAT_W + 1;
  localparam int DEPTH = 2 * LMAX + 2;

  op_e             op;
  logic            fire;
  logic [NB-1:0]   bank_open;
  logic [NB-1:0]   rcd_ok;
  logic            mrd_ok, mod_ok;
  logic            rd_busy, wr_busy, burst_busy;
  logic [SH_W-1:0] rl_sum, wl_sum, rd_sh, wr_sh;

  assign op   = op_e'(cmd_op);
  assign fire = cmd_valid && cmd_ready;
  assign burst_busy = rd_busy | wr_busy;

  always_comb begin
    case (op)
      OP_NOP:        cmd_ready = 1'b1;
      OP_ACT:        cmd_ready = mod_ok && !bank_open[cmd_bank];
      OP_RD, OP_WR:  cmd_ready = mod_ok && bank_open[cmd_bank] && rcd_ok[cmd_bank];
      OP_PRE:        cmd_ready = mod_ok;
      OP_MRS:        cmd_ready = mrd_ok && (bank_open == '0) && !burst_busy;
      default:       cmd_ready = 1'b0;
    endcase
  end

  // Window start offsets: latency minus the two register stages of the pipe.
  always_comb begin
    rl_sum = {1'b0, cfg_al} + {1'b0, cfg_cl};
    wl_sum = {1'b0, cfg_al} + {1'b0, cfg_cwl};
    rd_sh  = (rl_sum < SH_W'(2)) ? '0 : rl_sum - SH_W'(2);
    wr_sh  = (wl_sum < SH_W'(2)) ? '0 : wl_sum - SH_W'(2);
  end

  lat_bank_track #(.BANK_W(BANK_W), .TRCD(TRCD)) u_banks (
    .clk      (clk),
    .rst      (rst),
    .act_fire (fire && op == OP_ACT),
    .pre_fire (fire && op == OP_PRE),
    .bank     (cmd_bank),
    .open_o   (bank_open),
    .rcd_ok_o (rcd_ok)
  );

  lat_mr_gate #(
    .LAT_W(LAT_W), .TMRD(TMRD), .TMOD(TMOD), .CL_RST(CL_RST), .CWL_RST(CWL_RST)
  ) u_mr (
    .clk      (clk),
    .rst      (rst),
    .mrs_fire (fire && op == OP_MRS),
    .wdata    (mr_wdata),
    .mrd_ok   (mrd_ok),
    .mod_ok   (mod_ok),
    .al       (cfg_al),
    .cl       (cfg_cl),
    .cwl      (cfg_cwl),
    .asr      (cfg_asr),
    .srt      (cfg_srt),
    .rtt      (cfg_rtt_wr)
  );

  lat_win_pipe #(.DEPTH(DEPTH), .SH_W(SH_W)) u_rd_pipe (
    .clk      (clk),
    .rst      (rst),
    .fire     (fire && op == OP_RD),
    .start_sh (rd_sh),
    .chop     (cmd_bc4),
    .win_o    (rd_capture),
    .busy_o   (rd_busy)
  );

  lat_win_pipe #(.DEPTH(DEPTH), .SH_W(SH_W)) u_wr_pipe (
    .clk      (clk),
    .rst      (rst),
    .fire     (fire && op == OP_WR),
    .start_sh (wr_sh),
    .chop     (cmd_bc4),
    .win_o    (wr_drive),
    .busy_o   (wr_busy)
  );
endmodule

// File: rtl/lat_sched_chk.sv
module lat_sched_chk
  import lat_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int LAT_W  = 4,
  parameter int TMRD   = 4,
  parameter int TMOD   = 12
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   cmd_valid,
  input logic [2:0]             cmd_op,
  input logic                   cmd_ready,
  input logic [(2**BANK_W)-1:0] bank_open,
  input logic                   sel_open,
  input logic                   busy,
  input logic [LAT_W-1:0]       cfg_al,
  input logic [LAT_W-1:0]       cfg_cl,
  input logic [LAT_W-1:0]       cfg_cwl
);
  localparam int SAT   = (TMRD > TMOD) ? TMRD : TMOD;
  localparam int CNT_W = $clog2(SAT + 1);

  logic             acc, mrs_acc, oth_acc, rw_acc;
  logic [CNT_W-1:0] since_mrs;

  assign acc     = cmd_valid && cmd_ready;
  assign mrs_acc = acc && (cmd_op == OP_MRS);
  assign oth_acc = acc && (cmd_op != OP_MRS) && (cmd_op != OP_NOP);
  assign rw_acc  = acc && ((cmd_op == OP_RD) || (cmd_op == OP_WR));

  always_ff @(posedge clk) begin
    if (rst)                    since_mrs <= CNT_W'(SAT);
    else if (mrs_acc)           since_mrs <= CNT_W'(1);
    else if (since_mrs < CNT_W'(SAT)) since_mrs <= since_mrs + 1'b1;
  end

  a_r7_mrs_idle: assert property (@(posedge clk) disable iff (rst)
    mrs_acc |-> (bank_open == '0) && !busy);

  a_r9_mrd_gap: assert property (@(posedge clk) disable iff (rst)
    mrs_acc |-> since_mrs >= CNT_W'(TMRD));

  a_r9_mod_gap: assert property (@(posedge clk) disable iff (rst)
    oth_acc |-> since_mrs >= CNT_W'(TMOD));

  a_r6_open_bank: assert property (@(posedge clk) disable iff (rst)
    rw_acc |-> sel_open);

  a_r8_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(mrs_acc) |-> $stable({cfg_al, cfg_cl, cfg_cwl}));
endmodule

bind ddr_lat_sched lat_sched_chk #(
  .BANK_W(BANK_W), .LAT_W(LAT_W), .TMRD(TMRD), .TMOD(TMOD)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_ready (cmd_ready),
  .bank_open (bank_open),
  .sel_open  (bank_open[cmd_bank]),
  .busy      (burst_busy),
  .cfg_al    (cfg_al),
  .cfg_cl    (cfg_cl),
  .cfg_cwl   (cfg_cwl)
);

// File: tb/tb_ddr_lat_sched.sv
`timescale 1ns/1ps
module tb_ddr_lat_sched;
  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3,
                         PRE = 3'd4, MRS = 3'd5;
  localparam logic [15:0] MR_DEF = 16'h0550;  // AL0 CL5 CWL5
  localparam logic [15:0] MR_NEW = 16'h9765;  // AL5 CL6 CWL7 asr1 srt0 rtt2

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [2:0]  cmd_bank = 3'd0;
  logic        cmd_bc4 = 1'b0;
  logic [15:0] mr_wdata = 16'h0;
  logic        cmd_ready, rd_capture, wr_drive;
  logic [3:0]  cfg_al, cfg_cl, cfg_cwl;
  logic        cfg_asr, cfg_srt;
  logic [1:0]  cfg_rtt_wr;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic rd_log [4096];
  logic wr_log [4096];

  ddr_lat_sched dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_bc4(cmd_bc4), .mr_wdata(mr_wdata),
    .cmd_ready(cmd_ready), .rd_capture(rd_capture), .wr_drive(wr_drive),
    .cfg_al(cfg_al), .cfg_cl(cfg_cl), .cfg_cwl(cfg_cwl),
    .cfg_asr(cfg_asr), .cfg_srt(cfg_srt), .cfg_rtt_wr(cfg_rtt_wr)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (cyc < 4096) begin
    rd_log[cyc] = rd_capture;
    wr_log[cyc] = wr_drive;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op, input int bank, input bit bc4,
                      input logic [15:0] d, output bit acc, output int at);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_bank = 3'(bank);
    cmd_bc4 = bc4; mr_wdata = d;
    #1;
    acc = cmd_ready;
    at  = cyc;
  endtask

  task automatic release_cmd();
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = NOP;
  endtask

  task automatic idle_to(input int target);
    while (cyc < target - 1) @(negedge clk);
  endtask

  task automatic chk_win(input string req, input bit is_rd, input int start, input int len);
    while (cyc < start + len + 2) @(negedge clk);
    for (int j = start - 1; j <= start + len; j++) begin
      int exp_v;
      int act_v;
      exp_v = (j >= start && j < start + len) ? 1 : 0;
      act_v = is_rd ? int'(rd_log[j]) : int'(wr_log[j]);
      chk(req, $sformatf("%s window cyc+%0d", is_rd ? "rd" : "wr", j - start), act_v, exp_v);
    end
  endtask

  task automatic chk_defaults(input string req);
    chk(req, "cfg_al", cfg_al, 0);
    chk(req, "cfg_cl", cfg_cl, 5);
    chk(req, "cfg_cwl", cfg_cwl, 5);
    chk(req, "flags", {cfg_asr, cfg_srt, cfg_rtt_wr}, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "rd_capture", rd_capture, 0);
    chk("R1", "wr_drive", wr_drive, 0);
    chk_defaults("R1");
  endtask

  task automatic t_default_rw();
    bit ok; int a, r, w;
    send(ACT, 2, 0, 0, ok, a); chk("R2", "act accepted", ok, 1);
    release_cmd();
    idle_to(a + 3);
    send(RD, 2, 0, 0, ok, r); chk("R2", "read accepted", ok, 1);
    send(WR, 2, 1, 0, ok, w); chk("R2", "write accepted", ok, 1);
    send(3'd7, 2, 0, 0, ok, a); chk("R2", "code 7 refused", ok, 0);
    release_cmd();
    chk_win("R3/R5 bl8", 1, r + 5, 4);
    chk_win("R4/R5 bc4", 0, w + 5, 2);
  endtask

  task automatic t_rcd();
    bit ok; int a, t;
    send(ACT, 5, 0, 0, ok, a); chk("R6", "act b5", ok, 1);
    send(RD, 5, 0, 0, ok, t);  chk("R6", "read at trcd-2", ok, 0);
    send(WR, 5, 0, 0, ok, t);  chk("R6", "write at trcd-1", ok, 0);
    send(RD, 5, 1, 0, ok, t);  chk("R6", "read at trcd", ok, 1);
    send(RD, 6, 0, 0, ok, t);  chk("R6", "read closed bank", ok, 0);
    send(ACT, 5, 0, 0, ok, t); chk("R6", "act open bank", ok, 0);
    send(PRE, 5, 0, 0, ok, t); chk("R6", "pre b5", ok, 1);
    send(WR, 5, 0, 0, ok, t);  chk("R6", "write after pre", ok, 0);
    send(PRE, 2, 0, 0, ok, t); chk("R6", "pre b2", ok, 1);
    release_cmd();
  endtask

  task automatic t_mrs_gate();
    bit ok; int a, r, t, m, m2;
    send(ACT, 1, 0, 0, ok, a); chk("R7", "act b1", ok, 1);
    send(MRS, 0, 0, MR_DEF, ok, t); chk("R7", "mrs with bank open", ok, 0);
    release_cmd();
    idle_to(a + 3);
    send(RD, 1, 0, 0, ok, r); chk("R7", "read b1", ok, 1);
    send(PRE, 1, 0, 0, ok, t); chk("R7", "pre b1", ok, 1);
    for (int k = 2; k <= 8; k++) begin
      send(MRS, 0, 0, MR_DEF, ok, t);
      chk("R7", $sformatf("mrs during burst at read+%0d", t - r), ok, 0);
    end
    send(MRS, 0, 0, MR_DEF, ok, m); chk("R7", "mrs after last window cycle", ok, 1);
    chk("R7", "mrs cycle", m - r, 9);
    for (int k = 1; k < 4; k++) begin
      send(MRS, 0, 0, MR_NEW, ok, t);
      chk("R9", $sformatf("mrs at +%0d", t - m), ok, 0);
    end
    send(MRS, 0, 0, MR_NEW, ok, m2); chk("R9", "mrs at tmrd", ok, 1);
    release_cmd();
    @(negedge clk);
    chk("R8", "cfg_al", cfg_al, 5);
    chk("R8", "cfg_cl", cfg_cl, 6);
    chk("R8", "cfg_cwl", cfg_cwl, 7);
    chk("R8", "cfg_asr", cfg_asr, 1);
    chk("R8", "cfg_srt", cfg_srt, 0);
    chk("R8", "cfg_rtt_wr", cfg_rtt_wr, 2);
    idle_to(m2 + 11);
    send(ACT, 3, 0, 0, ok, t); chk("R9", "act at tmod-1", ok, 0);
    send(ACT, 3, 0, 0, ok, t); chk("R9", "act at tmod", ok, 1);
    chk("R9", "act cycle", t - m2, 12);
    release_cmd();
    idle_to(t + 3);
    begin
      int rr, ww;
      send(RD, 3, 1, 0, ok, rr); chk("R3", "read new latency", ok, 1);
      send(WR, 3, 0, 0, ok, ww); chk("R4", "write new latency", ok, 1);
      release_cmd();
      chk_win("R3/R5 al5 cl6 bc4", 1, rr + 11, 2);
      chk_win("R4/R5 al5 cwl7 bl8", 0, ww + 12, 4);
    end
  endtask

  task automatic t_b2b();
    bit ok; int c1, c2;
    send(RD, 3, 0, 0, ok, c1); chk("R5", "first read", ok, 1);
    release_cmd();
    idle_to(c1 + 6);
    send(RD, 3, 0, 0, ok, c2); chk("R5", "second read", ok, 1);
    release_cmd();
    chk_win("R5 first", 1, c1 + 11, 4);
    chk_win("R5 second", 1, c2 + 11, 4);
  endtask

  task automatic t_reset2();
    bit ok; int t;
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_defaults("R10");
    send(RD, 3, 0, 0, ok, t); chk("R10", "bank closed by reset", ok, 0);
    release_cmd();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_default_rw();
    t_rcd();
    t_mrs_gate();
    t_b2b();
    t_reset2();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule